// File: doc/BRIEF.md
# USB Root Port Ownership Router

This block decides which of two host controllers drives one downstream USB root port. One is the high-speed controller; the other is a companion controller for full-speed and low-speed devices. A global configure flag and a per-port owner bit set the routing. Only the current owner sees the port's connect status. Each controller has a sticky change bit that records every connect or disconnect it observes. Ownership moving from one controller to the other therefore shows up as a connect on one side and a disconnect on the other.

The block also decides whether the port is enabled when a port reset completes. The high-speed controller keeps the port enabled only if the line logic reported a high-speed device. Otherwise the enable stays clear and software is expected to hand the port over. A debug override, which applies only to the port with index 0, pins ownership to the high-speed controller.

Top module: `usb_port_router`

## Requirements
- R1: After reset `owner_cp` is 1, `port_en` is 0, and `hs_csc` and `cp_csc` are both 0.
- R2: With `cfg_flag` low and no debug override active, `owner_cp` is 1 from the next cycle, whatever device is attached.
- R3: In every cycle `hs_connect` equals `dev_present` AND NOT `owner_cp`, and `cp_connect` equals `dev_present` AND `owner_cp`. A controller that does not own the port never sees the device.
- R4: A rise of `cfg_flag` from 0 to 1 makes `owner_cp` 0 on the next cycle. This takes priority over `owner_wr1` and the disconnect return in that cycle.
- R5: A `reset_done` pulse with `hs_detected` high, while `hs_connect` is high, `cfg_flag` is high and `owner_wr1` is low, sets `port_en` on the next cycle. Ownership stays with the high-speed side.
- R6: A `reset_done` pulse with `hs_detected` low leaves `port_en` at 0 on the next cycle.
- R7: An `owner_wr1` pulse while `cfg_flag` is high and was already high makes `owner_cp` 1 and `port_en` 0 on the next cycle. One cycle later `cp_csc` and `hs_csc` are both set when a device is present.
- R8: While the companion owns the port and `cfg_flag` is high, a falling `dev_present` returns ownership: `owner_cp` is 0 on the next cycle. The companion's `cp_csc` records the disconnect, and `hs_csc` stays clear.
- R9: A change of `hs_connect` (or `cp_connect`) sets `hs_csc` (or `cp_csc`) on the following edge. The bit holds until a cycle with `hs_csc_clr` (or `cp_csc_clr`) high and no new change. A set wins over a clear in the same cycle.
- R10: A fall of `cfg_flag` from 1 to 0 makes `owner_cp` 1 and clears `port_en` on the next cycle.
- R11: With parameter PORT_INDEX = 0, `dbg_mode` high makes `owner_cp` 0 on the next cycle, overriding `cfg_flag` and `owner_wr1`. With any other PORT_INDEX, `dbg_mode` has no effect on `owner_cp`.
- R12: `port_en` is 0 in any cycle where `owner_cp` is 1. It clears on the cycle after `hs_connect` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flag | input | 1 | Global configure flag; 1 routes ports to the high-speed controller |
| dbg_mode | input | 1 | Debug override; pins port 0 to the high-speed controller |
| owner_wr1 | input | 1 | One-cycle pulse: software wrote 1 to the owner bit |
| dev_present | input | 1 | Raw device-attached indication from the line logic |
| hs_detected | input | 1 | High-speed handshake result, valid with reset_done |
| reset_done | input | 1 | One-cycle pulse: port reset has completed |
| hs_csc_clr | input | 1 | Write-1-to-clear for the high-speed change bit |
| cp_csc_clr | input | 1 | Write-1-to-clear for the companion change bit |
| owner_cp | output | 1 | 1 = companion owns the port, 0 = high-speed controller owns it |
| hs_connect | output | 1 | Connect status seen by the high-speed controller |
| cp_connect | output | 1 | Connect status seen by the companion controller |
| hs_csc | output | 1 | Sticky connect-change bit of the high-speed controller |
| cp_csc | output | 1 | Sticky connect-change bit of the companion controller |
| port_en | output | 1 | Port enable of the high-speed controller |

## Verification
The assertions assume only that every input is synchronous to `clk` and settles before the edge. Each property is written under the enabling conditions its requirement states, so no particular order of pulses is needed. In the bench, inputs change only at the falling edge. A pseudo-random sweep also applies combinations the line logic would never produce, such as `reset_done` without a device or an owner write in the same cycle as a flag edge. This shows that the priorities in R4, R10 and R11 settle every conflict.

// File: rtl/usb_port_router.sv
module usb_port_router #(
  parameter int PORT_INDEX = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_flag,
  input  logic dbg_mode,
  input  logic owner_wr1,
  input  logic dev_present,
  input  logic hs_detected,
  input  logic reset_done,
  input  logic hs_csc_clr,
  input  logic cp_csc_clr,
  output logic owner_cp,
  output logic hs_connect,
  output logic cp_connect,
  output logic hs_csc,
  output logic cp_csc,
  output logic port_en
);

  localparam bit DBG_CAPABLE = (PORT_INDEX == 0);

  logic owner_q, owner_d;
  logic cfg_q, dev_q;
  logic hs_prev_q, cp_prev_q;
  logic hs_csc_q, cp_csc_q;
  logic pe_q, pe_d;
  logic dbg_force, cfg_rise, dev_fall;

  assign dbg_force  = dbg_mode & DBG_CAPABLE;
  assign cfg_rise   = cfg_flag & ~cfg_q;
  assign dev_fall   = dev_q & ~dev_present;

  assign hs_connect = dev_present & ~owner_q;
  assign cp_connect = dev_present &  owner_q;

  always_comb begin
    if (dbg_force)                     owner_d = 1'b0;
    else if (!cfg_flag)                owner_d = 1'b1;
    else if (cfg_rise)                 owner_d = 1'b0;
    else if (owner_wr1)                owner_d = 1'b1;
    else if (owner_q && dev_fall)      owner_d = 1'b0;
    else                               owner_d = owner_q;
  end

  always_comb begin
    pe_d = pe_q;
    if (reset_done && hs_connect) pe_d = hs_detected;
    if (!hs_connect || owner_d)   pe_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= 1'b1;
      cfg_q     <= 1'b0;
      dev_q     <= 1'b0;
      hs_prev_q <= 1'b0;
      cp_prev_q <= 1'b0;
      hs_csc_q  <= 1'b0;
      cp_csc_q  <= 1'b0;
      pe_q      <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      cfg_q     <= cfg_flag;
      dev_q     <= dev_present;
      hs_prev_q <= hs_connect;
      cp_prev_q <= cp_connect;
      hs_csc_q  <= (hs_connect != hs_prev_q) | (hs_csc_q & ~hs_csc_clr);
      cp_csc_q  <= (cp_connect != cp_prev_q) | (cp_csc_q & ~cp_csc_clr);
      pe_q      <= pe_d;
    end
  end

  assign owner_cp = owner_q;
  assign hs_csc   = hs_csc_q;
  assign cp_csc   = cp_csc_q;
  assign port_en  = pe_q;

  a_r2_cfg_low_companion: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_flag && !(dbg_mode && DBG_CAPABLE)) |=> owner_cp);

  a_r11_debug_pins_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && DBG_CAPABLE) |=> !owner_cp);

  a_r4_flag_rise_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flag && !cfg_q && !dbg_mode) |=> !owner_cp);

  a_r5_hs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done && hs_detected && hs_connect && cfg_flag && !owner_wr1) |=> (port_en && !owner_cp));

  a_r6_fs_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done && !hs_detected) |=> !port_en);

  a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_wr1 && cfg_flag && cfg_q && !dbg_mode) |=> (owner_cp && !port_en));

  a_r9_hs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_csc && !hs_csc_clr) |=> hs_csc);

  a_r9_cp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_csc && !cp_csc_clr) |=> cp_csc);

  a_r12_enable_needs_hs_owner: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> !owner_cp);

  a_r12_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_connect |=> !port_en);

endmodule

// File: tb/usb_port_router_bench.sv
module usb_port_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_flag = 0, dbg_mode = 0, owner_wr1 = 0, dev_present = 0;
  logic hs_detected = 0, reset_done = 0, hs_csc_clr = 0, cp_csc_clr = 0;
  logic owner_cp, hs_connect, cp_connect, hs_csc, cp_csc, port_en;
  logic p1_owner, p1_hsc, p1_cpc, p1_hs, p1_cp, p1_pe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic m_owner, m_cfg, m_dev, m_hsp, m_cpp, m_hsc, m_cpc, m_pe;

  always #4 clk = ~clk;

  usb_port_router #(.PORT_INDEX(0)) u_usb_port_router (
    .clk(clk), .rst_n(rst_n), .cfg_flag(cfg_flag), .dbg_mode(dbg_mode),
    .owner_wr1(owner_wr1), .dev_present(dev_present), .hs_detected(hs_detected),
    .reset_done(reset_done), .hs_csc_clr(hs_csc_clr), .cp_csc_clr(cp_csc_clr),
    .owner_cp(owner_cp), .hs_connect(hs_connect), .cp_connect(cp_connect),
    .hs_csc(hs_csc), .cp_csc(cp_csc), .port_en(port_en));

  usb_port_router #(.PORT_INDEX(1)) u_usb_port_router_p1 (
    .clk(clk), .rst_n(rst_n), .cfg_flag(cfg_flag), .dbg_mode(dbg_mode),
    .owner_wr1(owner_wr1), .dev_present(dev_present), .hs_detected(hs_detected),
    .reset_done(reset_done), .hs_csc_clr(hs_csc_clr), .cp_csc_clr(cp_csc_clr),
    .owner_cp(p1_owner), .hs_connect(p1_hs), .cp_connect(p1_cp),
    .hs_csc(p1_hsc), .cp_csc(p1_cpc), .port_en(p1_pe));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_owner = 1; m_cfg = 0; m_dev = 0; m_hsp = 0; m_cpp = 0; m_hsc = 0; m_cpc = 0; m_pe = 0;
  endtask

  // next state from the requirements, evaluated with the inputs of the coming edge
  task automatic model_step();
    logic hs_v, cp_v, o_n, p_n;
    hs_v = dev_present & ~m_owner;
    cp_v = dev_present & m_owner;
    if (dbg_mode)                              o_n = 0;  // R11
    else if (!cfg_flag)                        o_n = 1;  // R2 R10
    else if (!m_cfg)                           o_n = 0;  // R4
    else if (owner_wr1)                        o_n = 1;  // R7
    else if (m_owner && m_dev && !dev_present) o_n = 0;  // R8
    else                                       o_n = m_owner;
    p_n = m_pe;
    if (reset_done && hs_v) p_n = hs_detected;           // R5 R6
    if (!hs_v || o_n) p_n = 0;                           // R12
    m_hsc = (hs_v != m_hsp) | (m_hsc & ~hs_csc_clr);     // R9
    m_cpc = (cp_v != m_cpp) | (m_cpc & ~cp_csc_clr);
    m_hsp = hs_v; m_cpp = cp_v;
    m_owner = o_n; m_pe = p_n; m_cfg = cfg_flag; m_dev = dev_present;
  endtask

  task automatic compare_model();
    chk("R2 R4 R7 R8 R10 R11", "owner_cp model", owner_cp, m_owner);
    chk("R3", "hs_connect model", hs_connect, dev_present & ~m_owner);
    chk("R3", "cp_connect model", cp_connect, dev_present & m_owner);
    chk("R9", "hs_csc model", hs_csc, m_hsc);
    chk("R9", "cp_csc model", cp_csc, m_cpc);
    chk("R5 R6 R12", "port_en model", port_en, m_pe);
  endtask

  task automatic step(input logic cf, input logic db, input logic wr, input logic dv,
                      input logic hd, input logic rd, input logic hc, input logic cc);
    cfg_flag = cf; dbg_mode = db; owner_wr1 = wr; dev_present = dv;
    hs_detected = hd; reset_done = rd; hs_csc_clr = hc; cp_csc_clr = cc;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "owner_cp after reset", owner_cp, 1'b1);
    chk("R1", "port_en after reset", port_en, 1'b0);
    chk("R1", "hs_csc after reset", hs_csc, 1'b0);
    chk("R1", "cp_csc after reset", cp_csc, 1'b0);
    rst_n = 1'b1;

    // flag low: companion sees device
    step(0,0,0,1, 0,0,0,0);
    chk("R2", "owner stays companion", owner_cp, 1'b1);
    chk("R3", "hs blind to device", hs_connect, 1'b0);
    chk("R3", "cp sees device", cp_connect, 1'b1);
    chk("R9", "cp change set", cp_csc, 1'b1);
    step(0,0,0,1, 0,0,0,1);
    chk("R9", "cp change cleared by write 1", cp_csc, 1'b0);
    chk("R3", "hs change never set", hs_csc, 1'b0);
    step(0,0,0,1, 0,0,0,0);
    chk("R9", "cp change stays clear", cp_csc, 1'b0);

    // flag rises: high-speed side owns
    step(1,0,0,0, 0,0,0,0);
    chk("R4", "flag rise gives hs ownership", owner_cp, 1'b0);
    step(1,0,0,1, 0,0,0,1);
    chk("R3", "hs sees connect", hs_connect, 1'b1);
    chk("R9", "hs change set", hs_csc, 1'b1);
    chk("R3", "cp does not see connect", cp_csc, 1'b0);
    step(1,0,0,1, 0,1,1,0);
    chk("R6", "full-speed reset leaves enable clear", port_en, 1'b0);
    step(1,0,0,1, 1,1,0,0);
    chk("R5", "high-speed reset enables", port_en, 1'b1);
    chk("R5", "hs keeps ownership", owner_cp, 1'b0);

    // handoff by owner write
    step(1,0,1,1, 0,0,0,0);
    chk("R7", "owner write gives companion", owner_cp, 1'b1);
    chk("R7", "enable cleared on handoff", port_en, 1'b0);
    step(1,0,0,1, 0,0,0,0);
    chk("R7", "hs sees disconnect event", hs_csc, 1'b1);
    chk("R7", "cp sees connect event", cp_csc, 1'b1);
    chk("R7", "cp connect status", cp_connect, 1'b1);
    step(1,0,0,1, 0,0,1,1);

    // disconnect returns port
    step(1,0,0,0, 0,0,0,0);
    chk("R8", "disconnect returns ownership", owner_cp, 1'b0);
    chk("R8", "companion records disconnect", cp_csc, 1'b1);
    chk("R8", "hs sees no event", hs_csc, 1'b0);
    step(1,0,0,0, 0,0,0,1);

    // flag fall
    step(1,0,0,1, 0,0,0,0);
    step(1,0,0,1, 1,1,1,0);
    chk("R5", "enable set again", port_en, 1'b1);
    step(0,0,0,1, 0,0,0,0);
    chk("R10", "flag fall gives companion", owner_cp, 1'b1);
    chk("R10", "flag fall clears enable", port_en, 1'b0);

    // debug override
    step(0,1,0,1, 0,0,0,0);
    chk("R11", "debug pins port 0 to hs", owner_cp, 1'b0);
    chk("R11", "debug ignored on port 1", p1_owner, 1'b1);
    step(0,1,1,1, 1,1,0,0);
    chk("R11", "debug beats owner write", owner_cp, 1'b0);
    chk("R11", "debug port enabled", port_en, 1'b1);
    step(0,0,0,1, 0,0,0,0);
    chk("R12", "release drops enable with owner", port_en, 1'b0);

    // enable follows device
    step(1,0,0,1, 0,0,1,1);
    step(1,0,0,1, 1,1,1,1);
    chk("R5", "enable before unplug", port_en, 1'b1);
    step(1,0,0,0, 0,0,0,0);
    chk("R12", "unplug clears enable", port_en, 1'b0);

    // pseudo-random sweep over all input combinations
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[9], lfsr[1] & lfsr[8] & lfsr[11], lfsr[2] & lfsr[10],
             lfsr[3] | lfsr[12], lfsr[4], lfsr[5], lfsr[6], lfsr[7]);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule